// File: doc/BRIEF.md
# Serial 5421-Code Nine's Complementer

This block accepts one decimal digit coded in the 5421 weighted code, one bit per enabled clock, most significant (weight-5) bit first. When the fourth bit of a digit has been taken in, it presents the nine's complement of that digit, again in 5421 code, as a 4-bit parallel word. A one-cycle strobe marks each completed digit, and a flag reports when the captured pattern is one of the six 4-bit values that the code does not use.

Bit position is tracked by a four-state machine: `ST_B0` (no bits held), `ST_B1` (one bit held), `ST_B2` (two bits held) and `ST_B3` (three bits held). Each transition happens only on a cycle with `bit_en` high: `ST_B0 -> ST_B1`, `ST_B1 -> ST_B2`, `ST_B2 -> ST_B3`, and the completing transition `ST_B3 -> ST_B0`, which issues the result. With `bit_en` low the state holds. The next enabled bit after a completed digit starts a new digit, with no gap needed.

Top module: `c5421_ninecomp`

## Requirements
- R1: After synchronous reset (`rst` high at a clock edge), `par_out` is 0000, `out_valid` is 0 and `code_err` is 0. Any partly received digit is discarded, so the next enabled bit is the first bit of a new digit.
- R2: Bits are taken MSB first. The first enabled bit of a digit is the weight-5 bit (bit 3), and the fourth is the weight-1 bit (bit 0).
- R3: The valid codes are 0=0000, 1=0001, 2=0010, 3=0011, 4=0100, 5=1000, 6=1001, 7=1010, 8=1011 and 9=1100. For a valid digit d, `par_out` becomes the code for 9-d, and `code_err` becomes 0.
- R4: If the captured pattern is 0101, 0110, 0111, 1101, 1110 or 1111, `code_err` becomes 1 and `par_out` becomes 0000.
- R5: `out_valid` is high for exactly one cycle, the cycle after the clock edge that accepts the fourth enabled bit. It is low at all other times.
- R6: `par_out` and `code_err` change only in the cycle where `out_valid` is high. They hold their values until the next digit completes.
- R7: Cycles with `bit_en` low do not advance the bit count and do not change the captured bits. Any number of idle cycles may fall between the bits of a digit.
- R8: Digits may follow each other back to back. An enabled bit in the cycle right after the fourth bit begins the next digit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ser_in | input | 1 | Serial data bit |
| bit_en | input | 1 | Qualifies `ser_in` for this cycle |
| par_out | output | 4 | Nine's complement in 5421 code |
| out_valid | output | 1 | One-cycle strobe for a completed digit |
| code_err | output | 1 | Captured pattern was not a valid code |

## Verification
Two events can fall in the same cycle. One is a result being issued (the `out_valid` cycle). The other is the first bit of the next digit being accepted. The bench provokes this by sending digits back to back with `bit_en` held high, so the new digit's MSB is shifted in while the previous result is being strobed. It then checks three things: that result's value, that the result holds while the next digit is assembled, and that the next digit's complement is correct. A reset in the middle of a digit, followed by a full digit, shows that the leftover bits did not leak into the new digit.

// File: rtl/c5421_pkg.sv
package c5421_pkg;
    localparam int DIG_W = 4;
    localparam int CNT_W = $clog2(DIG_W);

    typedef enum logic [CNT_W-1:0] {
        ST_B0 = 2'd0,
        ST_B1 = 2'd1,
        ST_B2 = 2'd2,
        ST_B3 = 2'd3
    } pos_t;

    typedef struct packed {
        logic [DIG_W-1:0] code;
        logic             bad;
    } conv_t;

    // 5421 code -> decimal value; returns 15 for unused patterns
    function automatic logic [3:0] code_to_dec(input logic [DIG_W-1:0] c);
        logic [3:0] v;
        v = 4'd15;
        if (c[3] == 1'b0) begin
            if (c[2] == 1'b0)           v = {2'b00, c[1:0]};
            else if (c[1:0] == 2'b00)   v = 4'd4;
        end else begin
            if (c[2] == 1'b0)           v = 4'd5 + {2'b00, c[1:0]};
            else if (c[1:0] == 2'b00)   v = 4'd9;
        end
        return v;
    endfunction

    // decimal value -> 5421 code
    function automatic logic [DIG_W-1:0] dec_to_code(input logic [3:0] d);
        logic [DIG_W-1:0] c;
        if (d < 4'd4)       c = {2'b00, d[1:0]};
        else if (d == 4'd4) c = 4'b0100;
        else if (d < 4'd9)  c = {2'b10, 2'(d - 4'd5)};
        else                c = 4'b1100;
        return c;
    endfunction
endpackage

// File: rtl/c5421_shifter.sv
module c5421_shifter #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         shift_en,
    input  logic         din,
    output logic [W-1:0] q,
    output logic [W-1:0] q_next
);
    assign q_next = {q[W-2:0], din};

    always_ff @(posedge clk) begin
        if (rst)           q <= '0;
        else if (shift_en) q <= q_next;
    end
endmodule

// File: rtl/c5421_conv.sv
module c5421_conv
    import c5421_pkg::*;
(
    input  logic [DIG_W-1:0] code_in,
    output conv_t            res
);
    logic [3:0] dec;

    always_comb begin
        dec = code_to_dec(code_in);
        if (dec > 4'd9) begin
            res.code = '0;
            res.bad  = 1'b1;
        end else begin
            res.code = dec_to_code(4'd9 - dec);
            res.bad  = 1'b0;
        end
    end
endmodule

// File: rtl/c5421_ninecomp.sv
module c5421_ninecomp
    import c5421_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ser_in,
    input  logic             bit_en,
    output logic [DIG_W-1:0] par_out,
    output logic             out_valid,
    output logic             code_err
);
    pos_t             st_q, st_d;
    logic [DIG_W-1:0] sh_q, sh_next;
    conv_t            conv;
    logic             done;

    c5421_shifter #(.W(DIG_W)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .shift_en (bit_en),
        .din      (ser_in),
        .q        (sh_q),
        .q_next   (sh_next)
    );

    c5421_conv u_conv (
        .code_in (sh_next),
        .res     (conv)
    );

    // next-state logic
    always_comb begin
        st_d = st_q;
        done = 1'b0;
        if (bit_en) begin
            unique case (st_q)
                ST_B0: st_d = ST_B1;
                ST_B1: st_d = ST_B2;
                ST_B2: st_d = ST_B3;
                ST_B3: begin
                    st_d = ST_B0;
                    done = 1'b1;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_B0;
        else     st_q <= st_d;
    end

    // output registers
    always_ff @(posedge clk) begin
        if (rst) begin
            par_out   <= '0;
            out_valid <= 1'b0;
            code_err  <= 1'b0;
        end else begin
            out_valid <= done;
            if (done) begin
                par_out  <= conv.code;
                code_err <= conv.bad;
            end
        end
    end
endmodule

// File: rtl/c5421_ninecomp_chk.sv
module c5421_ninecomp_chk (
    input logic       clk,
    input logic       rst,
    input logic       bit_en,
    input logic [3:0] par_out,
    input logic       out_valid,
    input logic       code_err
);
    logic [2:0] en_cnt;   // enabled bits since last completion
    logic       seen_clk;

    always_ff @(posedge clk) begin
        seen_clk <= 1'b1;
        if (rst)         en_cnt <= '0;
        else if (bit_en) en_cnt <= (en_cnt == 3'd3) ? 3'd0 : en_cnt + 3'd1;
    end

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (par_out == 4'd0 && !out_valid && !code_err));

    p_err_zero_r4: assert property (@(posedge clk) disable iff (rst)
        code_err |-> par_out == 4'd0);

    p_valid_single_r5: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    p_valid_on_fourth_r5: assert property (@(posedge clk) disable iff (rst)
        (bit_en && en_cnt == 3'd3) |=> out_valid);

    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (seen_clk && !out_valid && !$past(rst)) |-> ($stable(par_out) && $stable(code_err)));

    p_idle_no_valid_r7: assert property (@(posedge clk) disable iff (rst)
        !bit_en |=> !out_valid);
endmodule

bind c5421_ninecomp c5421_ninecomp_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bit_en    (bit_en),
    .par_out   (par_out),
    .out_valid (out_valid),
    .code_err  (code_err)
);

// File: tb/c5421_ninecomp_tb_top.sv
`timescale 1ns/1ps
module c5421_ninecomp_tb_top;
    logic       clk = 1'b0;
    logic       rst, ser_in, bit_en;
    logic [3:0] par_out;
    logic       out_valid, code_err;
    int         n_chk = 0, n_err = 0;

    always #2 clk = ~clk;   // 250 MHz

    c5421_ninecomp dut_i (
        .clk(clk), .rst(rst), .ser_in(ser_in), .bit_en(bit_en),
        .par_out(par_out), .out_valid(out_valid), .code_err(code_err)
    );

    function automatic logic [3:0] enc(input int d);
        return (d < 5) ? ((d == 4) ? 4'b0100 : 4'(d)) : (4'b1000 | 4'(d - 5));
    endfunction

    function automatic int dec_of(input logic [3:0] c);
        for (int d = 0; d < 10; d++) if (enc(d) == c) return d;
        return -1;
    endfunction

    task automatic chk(input string req, input logic [5:0] act, input logic [5:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    // drive one enabled bit; inputs change at negedge
    task automatic send_bit(input logic b);
        @(negedge clk); ser_in = b; bit_en = 1'b1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin @(negedge clk); bit_en = 1'b0; ser_in = ~ser_in; end
    endtask

    // exp: {out_valid, code_err, par_out}
    function automatic logic [5:0] expect_of(input logic [3:0] c);
        int d = dec_of(c);
        return (d < 0) ? 6'b110000 : {2'b10, enc(9 - d)};
    endfunction

    task automatic do_reset;
        @(negedge clk); rst = 1'b1; bit_en = 1'b0; ser_in = 1'b0;
        @(negedge clk); rst = 1'b0;
    endtask

    task automatic t_reset;
        do_reset;
        chk("R1 reset state", {out_valid, code_err, par_out}, 6'b000000);
    endtask

    task automatic t_all_codes;   // R2 R3 R4 R5
        for (int c = 0; c < 16; c++) begin
            for (int b = 3; b >= 0; b--) send_bit(4'(c) >> b);
            @(negedge clk); bit_en = 1'b0;
            chk("R3/R4 complement", {out_valid, code_err, par_out}, expect_of(4'(c)));
            @(negedge clk);
            chk("R5 valid single pulse", {5'b0, out_valid}, 6'b0);
        end
    endtask

    task automatic t_idle_gaps;   // R7 R6 R2
        logic [3:0] c = enc(7);
        logic [5:0] prev;
        prev = {1'b0, code_err, par_out};
        for (int b = 3; b >= 0; b--) begin
            send_bit(c[b]);
            if (b != 0) begin
                idle(3);
                chk("R6 hold while assembling", {1'b0, code_err, par_out}, prev);
                chk("R7 no valid on idle", {5'b0, out_valid}, 6'b0);
            end
        end
        @(negedge clk); bit_en = 1'b0;
        chk("R7 gaps tolerated", {out_valid, code_err, par_out}, {2'b10, enc(2)});
    endtask

    task automatic t_back_to_back;   // R8
        int ds[3] = '{3, 9, 5};
        for (int k = 0; k < 3; k++) begin
            for (int b = 3; b >= 0; b--) begin
                send_bit(enc(ds[k])[b]);
                if (k > 0 && b == 3)
                    chk("R8 overlap result", {out_valid, code_err, par_out}, {2'b10, enc(9 - ds[k-1])});
            end
        end
        @(negedge clk); bit_en = 1'b0;
        chk("R8 last of stream", {out_valid, code_err, par_out}, {2'b10, enc(4)});
    endtask

    task automatic t_mid_reset;   // R1
        send_bit(1'b1); send_bit(1'b1);
        do_reset;
        chk("R1 reset clears", {out_valid, code_err, par_out}, 6'b000000);
        for (int b = 3; b >= 0; b--) send_bit(enc(1)[b]);
        @(negedge clk); bit_en = 1'b0;
        chk("R1 partial discarded", {out_valid, code_err, par_out}, {2'b10, enc(8)});
    endtask

    task automatic t_err_then_valid;   // R4 R6
        for (int b = 3; b >= 0; b--) send_bit(4'b1110 >> b);
        @(negedge clk); bit_en = 1'b0;
        chk("R4 error flag", {out_valid, code_err, par_out}, 6'b110000);
        idle(5);
        chk("R6 error held", {out_valid, code_err, par_out}, 6'b010000);
        for (int b = 3; b >= 0; b--) send_bit(enc(0)[b]);
        @(negedge clk); bit_en = 1'b0;
        chk("R4 error cleared", {out_valid, code_err, par_out}, {2'b10, enc(9)});
    endtask

    initial begin
        rst = 1'b1; bit_en = 1'b0; ser_in = 1'b0;
        repeat (3) @(negedge clk);
        t_reset;
        t_all_codes;
        t_idle_gaps;
        t_back_to_back;
        t_mid_reset;
        t_err_then_valid;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #100000;
        n_chk++; n_err++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule